// File: doc/BRIEF.md
# Prioritised Interrupt Exception Entry

This block decides, on each request strobe, whether a pending interrupt may be taken, and if so performs the processor's exception entry for it. The strobe brings the interrupt level the controller has selected and the level the core currently masks at. It also brings the raised and enabled interrupt lines, the program counter and the status word. A qualifying interrupt redirects the program counter to a vector, rewrites the status word and saves the interrupted context. A one-cycle pulse announces each entry.

Levels above 1 are vectored directly, each with its own saved-PC and saved-status register. A level-1 interrupt is instead folded into the general exception path. It loads a fixed cause code and enters through the kernel, user or double-exception vector, chosen by the exception-mode and user-mode status bits. When vector relocation is configured, every target is moved by the distance between a runtime base register and the built-in base. The level count, per-level line masks, vector addresses and status bit positions are parameters.

Top module: `irq_entry_unit`

## Requirements
- R1: An interrupt is taken only if all three hold: `pend_lvl_i` is greater than `cur_lvl_i`, `pend_lvl_i` is at most NLEVEL, and the line mask of that level ANDed with `int_set_i` and `int_en_i` is nonzero. Level L's mask is bits [(L-1)*NLINES +: NLINES] of LEVEL_MASK.
- R2: When `req_i` is low or no interrupt qualifies, `pc_o`, `ps_o`, `cause_o`, `depc_o`, `epc_o` and `eps_o` keep their values and `taken_o` stays low.
- R3: `taken_o` is high for the one cycle after the clock edge that sampled a qualifying `req_i`; all other outputs take their new values at that same edge.
- R4: For a level L above 1, the PC is saved in slice [(L-1)*DW +: DW] of `epc_o` and the status word in slice [(L-2)*DW +: DW] of `eps_o`.
- R5: For a level L above 1, the status interrupt-level field (bits [LVLW-1:0]) becomes L, bit EXCM_BIT (default 4) is set, all other status bits are copied from `ps_i`, and the target is HI_VEC_BASE + (L-2)*HI_VEC_STRIDE.
- R6: For level 1, `cause_o` becomes L1_CAUSE and the new status word is `ps_i` with bit EXCM_BIT set and nothing else changed.
- R7: For level 1 with bit EXCM_BIT of `ps_i` clear, the PC is saved in level-1 slice of `epc_o`; the target is USER_VEC when bit UM_BIT (default 5) is set and KERNEL_VEC when it is clear.
- R8: For level 1 with bit EXCM_BIT of `ps_i` set, the target is DOUBLE_VEC; the PC is saved in `depc_o` when HAS_DEPC is 1 and in the level-1 slice of `epc_o` when HAS_DEPC is 0.
- R9: With RELOC set, the new PC is the target minus DEF_VECBASE plus `vecbase_i`; with RELOC clear it is the target unchanged.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Evaluate the presented interrupt this cycle |
| pend_lvl_i | input | LVLW | Level of the pending interrupt |
| cur_lvl_i | input | LVLW | Current interrupt mask level of the core |
| int_set_i | input | NLINES | Raised interrupt lines |
| int_en_i | input | NLINES | Enabled interrupt lines |
| pc_i | input | DW | Program counter of the interrupted instruction |
| ps_i | input | DW | Status word at the point of interruption |
| vecbase_i | input | DW | Runtime vector base |
| pc_o | output | DW | Program counter after entry |
| ps_o | output | DW | Status word after entry |
| cause_o | output | DW | Exception cause register |
| depc_o | output | DW | Double-exception saved PC |
| epc_o | output | NLEVEL*DW | Saved PC per level 1..NLEVEL |
| eps_o | output | (NLEVEL-1)*DW | Saved status per level 2..NLEVEL |
| taken_o | output | 1 | One-cycle entry pulse |

## Verification
The bench builds two copies with four levels and eight lines. One has a double-exception PC register and relocation; the other has neither. Each request goes to both, so one stimulus shows the two destinations of a double-exception PC and the relocated against the built-in vector address. Four levels let the level bound, the masking by current level and the per-level vector spacing be reached above and below the top level.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ENT_NONE   = 3'd0,
    ENT_HIGH   = 3'd1,
    ENT_KERNEL = 3'd2,
    ENT_USER   = 3'd3,
    ENT_DOUBLE = 3'd4
  } entry_kind_e;

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NLEVEL = 4,
  parameter int NLINES = 8,
  parameter int LVLW   = 4,
  parameter logic [NLEVEL*NLINES-1:0] LEVEL_MASK = '1
) (
  input  logic [LVLW-1:0]   pend_lvl,
  input  logic [LVLW-1:0]   cur_lvl,
  input  logic [NLINES-1:0] int_set,
  input  logic [NLINES-1:0] int_en,
  output logic              hit
);

  logic [NLINES-1:0] live;
  logic [NLEVEL:1]   lvl_live;
  logic              sel_live;

  assign live = int_set & int_en;

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_lvl
    assign lvl_live[g] = |(LEVEL_MASK[(g-1)*NLINES +: NLINES] & live);
  end

  always_comb begin
    sel_live = 1'b0;
    for (int l = 1; l <= NLEVEL; l++) begin
      if (pend_lvl == LVLW'(l)) sel_live = lvl_live[l];
    end
  end

  assign hit = (pend_lvl > cur_lvl) && (pend_lvl <= LVLW'(NLEVEL)) && sel_live;

endmodule

// File: rtl/irq_classify.sv
module irq_classify
  import irq_entry_pkg::*;
#(
  parameter int          DW            = 32,
  parameter int          LVLW          = 4,
  parameter int          EXCM_BIT      = 4,
  parameter int          UM_BIT        = 5,
  parameter logic [DW-1:0] KERNEL_VEC    = '0,
  parameter logic [DW-1:0] USER_VEC      = '0,
  parameter logic [DW-1:0] DOUBLE_VEC    = '0,
  parameter logic [DW-1:0] HI_VEC_BASE   = '0,
  parameter logic [DW-1:0] HI_VEC_STRIDE = '0
) (
  input  logic            hit,
  input  logic [LVLW-1:0] pend_lvl,
  input  logic [DW-1:0]   ps,
  output entry_kind_e     kind,
  output logic [DW-1:0]   vec
);

  logic [DW-1:0] hi_vec;

  assign hi_vec = HI_VEC_BASE + (DW'(pend_lvl) - DW'(2)) * HI_VEC_STRIDE;

  always_comb begin
    kind = ENT_NONE;
    vec  = '0;
    if (hit) begin
      if (pend_lvl > LVLW'(1)) begin
        kind = ENT_HIGH;
        vec  = hi_vec;
      end else if (ps[EXCM_BIT]) begin
        kind = ENT_DOUBLE;
        vec  = DOUBLE_VEC;
      end else if (ps[UM_BIT]) begin
        kind = ENT_USER;
        vec  = USER_VEC;
      end else begin
        kind = ENT_KERNEL;
        vec  = KERNEL_VEC;
      end
    end
  end

endmodule

// File: rtl/irq_vector_reloc.sv
module irq_vector_reloc #(
  parameter int            DW          = 32,
  parameter bit            RELOC       = 1'b1,
  parameter logic [DW-1:0] DEF_VECBASE = '0
) (
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] vecbase,
  output logic [DW-1:0] target
);

  if (RELOC) begin : g_reloc
    assign target = vec - DEF_VECBASE + vecbase;
  end else begin : g_fixed
    logic unused_base;
    assign unused_base = ^vecbase;
    assign target = vec;
  end

endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs
  import irq_entry_pkg::*;
#(
  parameter int NLEVEL   = 4,
  parameter int DW       = 32,
  parameter int LVLW     = 4,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  entry_kind_e              kind,
  input  logic [LVLW-1:0]          pend_lvl,
  input  logic [DW-1:0]            pc,
  input  logic [DW-1:0]            ps,
  output logic [NLEVEL*DW-1:0]     epc,
  output logic [(NLEVEL-1)*DW-1:0] eps,
  output logic [DW-1:0]            depc
);

  logic l1_to_epc;

  assign l1_to_epc = (kind == ENT_KERNEL) || (kind == ENT_USER) ||
                     ((kind == ENT_DOUBLE) && !HAS_DEPC);

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_epc
    logic          wr_en;
    logic [DW-1:0] epc_q;
    logic [DW-1:0] epc_d;

    if (g == 1) begin : g_l1
      assign wr_en = take && l1_to_epc;
    end else begin : g_hi
      assign wr_en = take && (kind == ENT_HIGH) && (pend_lvl == LVLW'(g));
    end

    always_comb begin
      epc_d = epc_q;
      if (wr_en) epc_d = pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) epc_q <= '0;
      else        epc_q <= epc_d;
    end

    assign epc[(g-1)*DW +: DW] = epc_q;
  end

  for (genvar g = 2; g <= NLEVEL; g++) begin : g_eps
    logic          wr_en;
    logic [DW-1:0] eps_q;
    logic [DW-1:0] eps_d;

    assign wr_en = take && (kind == ENT_HIGH) && (pend_lvl == LVLW'(g));

    always_comb begin
      eps_d = eps_q;
      if (wr_en) eps_d = ps;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eps_q <= '0;
      else        eps_q <= eps_d;
    end

    assign eps[(g-2)*DW +: DW] = eps_q;
  end

  if (HAS_DEPC) begin : g_depc
    logic          wr_en;
    logic [DW-1:0] depc_q;
    logic [DW-1:0] depc_d;

    assign wr_en = take && (kind == ENT_DOUBLE);

    always_comb begin
      depc_d = depc_q;
      if (wr_en) depc_d = pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) depc_q <= '0;
      else        depc_q <= depc_d;
    end

    assign depc = depc_q;
  end else begin : g_no_depc
    assign depc = '0;
  end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int            NLEVEL        = 4,
  parameter int            NLINES        = 8,
  parameter int            LVLW          = 4,
  parameter int            DW            = 32,
  parameter int            EXCM_BIT      = 4,
  parameter int            UM_BIT        = 5,
  parameter bit            HAS_DEPC      = 1'b1,
  parameter bit            RELOC         = 1'b1,
  parameter logic [NLEVEL*NLINES-1:0] LEVEL_MASK = 32'h8060_1807,
  parameter logic [DW-1:0] L1_CAUSE      = 32'd4,
  parameter logic [DW-1:0] DEF_VECBASE   = 32'h4000_0000,
  parameter logic [DW-1:0] KERNEL_VEC    = 32'h4000_0300,
  parameter logic [DW-1:0] USER_VEC      = 32'h4000_0340,
  parameter logic [DW-1:0] DOUBLE_VEC    = 32'h4000_03C0,
  parameter logic [DW-1:0] HI_VEC_BASE   = 32'h4000_0180,
  parameter logic [DW-1:0] HI_VEC_STRIDE = 32'h0000_0040
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic [LVLW-1:0]          pend_lvl_i,
  input  logic [LVLW-1:0]          cur_lvl_i,
  input  logic [NLINES-1:0]        int_set_i,
  input  logic [NLINES-1:0]        int_en_i,
  input  logic [DW-1:0]            pc_i,
  input  logic [DW-1:0]            ps_i,
  input  logic [DW-1:0]            vecbase_i,
  output logic [DW-1:0]            pc_o,
  output logic [DW-1:0]            ps_o,
  output logic [DW-1:0]            cause_o,
  output logic [DW-1:0]            depc_o,
  output logic [NLEVEL*DW-1:0]     epc_o,
  output logic [(NLEVEL-1)*DW-1:0] eps_o,
  output logic                     taken_o
);

  localparam logic [DW-1:0] LVL_FIELD = DW'((1 << LVLW) - 1);
  localparam logic [DW-1:0] EXCM_M    = DW'(1) << EXCM_BIT;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic          hit;
  logic          take;
  entry_kind_e   kind;
  logic [DW-1:0] vec;
  logic [DW-1:0] target;

  irq_qualify #(
    .NLEVEL(NLEVEL), .NLINES(NLINES), .LVLW(LVLW), .LEVEL_MASK(LEVEL_MASK)
  ) u_qual (
    .pend_lvl(pend_lvl_i), .cur_lvl(cur_lvl_i),
    .int_set(int_set_i), .int_en(int_en_i), .hit(hit)
  );

  assign take = req_i && hit;

  irq_classify #(
    .DW(DW), .LVLW(LVLW), .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT),
    .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC),
    .HI_VEC_BASE(HI_VEC_BASE), .HI_VEC_STRIDE(HI_VEC_STRIDE)
  ) u_cls (
    .hit(take), .pend_lvl(pend_lvl_i), .ps(ps_i), .kind(kind), .vec(vec)
  );

  irq_vector_reloc #(
    .DW(DW), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE)
  ) u_reloc (
    .vec(vec), .vecbase(vecbase_i), .target(target)
  );

  irq_save_regs #(
    .NLEVEL(NLEVEL), .DW(DW), .LVLW(LVLW), .HAS_DEPC(HAS_DEPC)
  ) u_save (
    .clk(clk), .rst_n(rst_sync_q), .take(take), .kind(kind),
    .pend_lvl(pend_lvl_i), .pc(pc_i), .ps(ps_i),
    .epc(epc_o), .eps(eps_o), .depc(depc_o)
  );

  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] ps_q, ps_d;
  logic [DW-1:0] cause_q, cause_d;
  logic          taken_q, taken_d;

  always_comb begin
    pc_d    = pc_q;
    ps_d    = ps_q;
    cause_d = cause_q;
    taken_d = take;
    if (take) begin
      pc_d = target;
      if (kind == ENT_HIGH) begin
        ps_d = (ps_i & ~LVL_FIELD) | DW'(pend_lvl_i) | EXCM_M;
      end else begin
        ps_d    = ps_i | EXCM_M;
        cause_d = L1_CAUSE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pc_q    <= '0;
      ps_q    <= '0;
      cause_q <= '0;
      taken_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      ps_q    <= ps_d;
      cause_q <= cause_d;
      taken_q <= taken_d;
    end
  end

  assign pc_o    = pc_q;
  assign ps_o    = ps_q;
  assign cause_o = cause_q;
  assign taken_o = taken_q;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int            NLEVEL   = 4,
  parameter int            LVLW     = 4,
  parameter int            DW       = 32,
  parameter int            EXCM_BIT = 4,
  parameter logic [DW-1:0] L1_CAUSE = 32'd4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_i,
  input logic [LVLW-1:0] pend_lvl_i,
  input logic [LVLW-1:0] cur_lvl_i,
  input logic [DW-1:0]   pc_o,
  input logic [DW-1:0]   ps_o,
  input logic [DW-1:0]   cause_o,
  input logic            taken_o
);

  // R3: an entry pulse follows only a sampled request
  p_pulse_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(req_i));

  // R1: a taken level exceeded the current level and lay within the level count
  p_level_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ($past(pend_lvl_i) > $past(cur_lvl_i)) &&
                ($past(pend_lvl_i) <= LVLW'(NLEVEL)));

  // R2: without an entry the visible state holds
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> $stable(pc_o) && $stable(ps_o) && $stable(cause_o));

  // R5: high-level entry writes its level into the status field
  p_hi_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && ($past(pend_lvl_i) > LVLW'(1))) |->
      (ps_o[LVLW-1:0] == $past(pend_lvl_i)));

  // R6: level-1 entry loads the fixed cause and sets exception mode
  p_l1_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && ($past(pend_lvl_i) == LVLW'(1))) |->
      (cause_o == L1_CAUSE) && ps_o[EXCM_BIT]);

endmodule

bind irq_entry_unit irq_entry_chk #(
  .NLEVEL(NLEVEL), .LVLW(LVLW), .DW(DW), .EXCM_BIT(EXCM_BIT), .L1_CAUSE(L1_CAUSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .pend_lvl_i(pend_lvl_i),
  .cur_lvl_i(cur_lvl_i), .pc_o(pc_o), .ps_o(ps_o), .cause_o(cause_o),
  .taken_o(taken_o)
);

// File: tb/sim_irq_entry_unit.sv
module sim_irq_entry_unit;

  localparam int NL = 4;
  localparam logic [31:0] KV = 32'h4000_0300, UV = 32'h4000_0340,
                          DV = 32'h4000_03C0, HB = 32'h4000_0180,
                          HS = 32'h40, DB = 32'h4000_0000;

  typedef struct {
    logic [31:0] pc, ps, cause, depc;
    logic [31:0] epc [5];
    logic [31:0] eps [5];
    logic        taken;
    string       tag;
  } model_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [3:0]  pend = '0, cur = '0;
  logic [7:0]  iset = '0, ien = '0;
  logic [31:0] pc = '0, ps = '0, vb = '0;

  logic [31:0] pc0, ps0, cause0, depc0, pc1, ps1, cause1, depc1;
  logic [127:0] epc0, epc1;
  logic [95:0]  eps0, eps1;
  logic taken0, taken1;

  int checks = 0, failures = 0;
  bit done = 0;
  model_t q0[$], q1[$];
  model_t m0, m1;

  always #5 clk = ~clk;

  irq_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pend_lvl_i(pend), .cur_lvl_i(cur),
    .int_set_i(iset), .int_en_i(ien), .pc_i(pc), .ps_i(ps), .vecbase_i(vb),
    .pc_o(pc0), .ps_o(ps0), .cause_o(cause0), .depc_o(depc0),
    .epc_o(epc0), .eps_o(eps0), .taken_o(taken0)
  );

  irq_entry_unit #(.HAS_DEPC(1'b0), .RELOC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pend_lvl_i(pend), .cur_lvl_i(cur),
    .int_set_i(iset), .int_en_i(ien), .pc_i(pc), .ps_i(ps), .vecbase_i(vb),
    .pc_o(pc1), .ps_o(ps1), .cause_o(cause1), .depc_o(depc1),
    .epc_o(epc1), .eps_o(eps1), .taken_o(taken1)
  );

  function automatic logic [7:0] mask_of(logic [3:0] l);
    case (l)
      4'd1: return 8'h07;
      4'd2: return 8'h18;
      4'd3: return 8'h60;
      4'd4: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic model_t step(model_t s, bit has_depc, bit rel, string tag);
    model_t n = s;
    logic [31:0] v;
    n.taken = 1'b0;
    n.tag = tag;
    if (pend > cur && pend <= 4'(NL) && (mask_of(pend) & iset & ien) != 0) begin
      n.taken = 1'b1;
      if (pend > 4'd1) begin
        n.epc[pend] = pc;
        n.eps[pend] = ps;
        n.ps = (ps & ~32'hF) | 32'(pend) | 32'h10;
        v = HB + (32'(pend) - 32'd2) * HS;
      end else begin
        n.cause = 32'd4;
        if (ps[4]) begin
          v = DV;
          if (has_depc) n.depc = pc; else n.epc[1] = pc;
        end else begin
          n.epc[1] = pc;
          v = ps[5] ? UV : KV;
        end
        n.ps = ps | 32'h10;
      end
      n.pc = rel ? v - DB + vb : v;
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(model_t e, string u, logic [31:0] a_pc, a_ps, a_cause,
                     a_depc, logic [127:0] a_epc, logic [95:0] a_eps, logic a_tk);
    chk(e.tag, {u, " taken"}, 32'(a_tk), 32'(e.taken));
    chk(e.tag, {u, " pc"}, a_pc, e.pc);
    chk(e.tag, {u, " ps"}, a_ps, e.ps);
    chk(e.tag, {u, " cause"}, a_cause, e.cause);
    chk(e.tag, {u, " depc"}, a_depc, e.depc);
    for (int l = 1; l <= NL; l++) chk(e.tag, {u, " epc"}, a_epc[(l-1)*32 +: 32], e.epc[l]);
    for (int l = 2; l <= NL; l++) chk(e.tag, {u, " eps"}, a_eps[(l-2)*32 +: 32], e.eps[l]);
  endtask

  // driver: presents one request and pushes the expected result
  task automatic drive(string tag, logic [3:0] p, logic [3:0] c, logic [7:0] s,
                       logic [7:0] en, logic [31:0] vpc, logic [31:0] vps,
                       logic [31:0] vvb);
    @(negedge clk);
    pend = p; cur = c; iset = s; ien = en; pc = vpc; ps = vps; vb = vvb;
    req = 1'b1;
    m0 = step(m0, 1'b1, 1'b1, tag);
    m1 = step(m1, 1'b0, 1'b0, tag);
    q0.push_back(m0);
    q1.push_back(m1);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  // monitor: compares after each edge that consumed a request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q0.size() > 0) begin
        model_t e0, e1;
        e0 = q0.pop_front();
        e1 = q1.pop_front();
        cmp(e0, "u0", pc0, ps0, cause0, depc0, epc0, eps0, taken0);
        cmp(e1, "u1", pc1, ps1, cause1, depc1, epc1, eps1, taken1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m0.pc = '0; m0.ps = '0; m0.cause = '0; m0.depc = '0; m0.taken = 1'b0;
    for (int l = 0; l < 5; l++) begin m0.epc[l] = '0; m0.eps[l] = '0; end
    m1 = m0;
    repeat (3) @(negedge clk);
    // R10: everything zero while in reset
    chk("R10", "pc", pc0, 0);
    chk("R10", "ps", ps0, 0);
    chk("R10", "epc", epc0[31:0], 0);
    chk("R10", "taken", 32'(taken0), 0);
    rst_n = 1'b1;
    idle(4);
    // R1/R2: non-qualifying requests
    drive("R1", 4'd2, 4'd2, 8'h08, 8'hFF, 32'h100, 32'h2, 32'h8000_0000);
    drive("R1", 4'd5, 4'd0, 8'hFF, 8'hFF, 32'h104, 32'h0, 32'h8000_0000);
    drive("R1", 4'd2, 4'd0, 8'h08, 8'h00, 32'h108, 32'h0, 32'h8000_0000);
    drive("R2", 4'd2, 4'd0, 8'h01, 8'hFF, 32'h10C, 32'h0, 32'h8000_0000);
    drive("R2", 4'd4, 4'd4, 8'hFF, 8'hFF, 32'h110, 32'h0, 32'h8000_0000);
    idle(2);
    // R4/R5/R9: high-level entries
    drive("R4", 4'd2, 4'd1, 8'h08, 8'hFF, 32'h1000, 32'h21, 32'h8000_0000);
    idle(1);
    drive("R5", 4'd4, 4'd3, 8'h80, 8'h80, 32'h2000, 32'hA3, 32'h8000_0000);
    drive("R5", 4'd3, 4'd0, 8'h40, 8'hFF, 32'h3000, 32'h1F, 32'h9000_0000);
    idle(2);
    // R6/R7: level-1 kernel and user
    drive("R7", 4'd1, 4'd0, 8'h01, 8'hFF, 32'h4000, 32'h0, 32'h8000_0000);
    drive("R7", 4'd1, 4'd0, 8'h04, 8'h04, 32'h5000, 32'h20, 32'h8000_0000);
    idle(1);
    // R8: double exception
    drive("R8", 4'd1, 4'd0, 8'h02, 8'hFF, 32'h6000, 32'h10, 32'h8000_0000);
    drive("R6", 4'd1, 4'd0, 8'h02, 8'hFF, 32'h7000, 32'h130, 32'h8000_0000);
    idle(1);
    // R9: relocation with a different base; R3: back-to-back entries
    drive("R9", 4'd2, 4'd0, 8'h10, 8'hFF, 32'h8000, 32'h0, 32'hC000_1000);
    drive("R3", 4'd3, 4'd2, 8'h20, 8'hFF, 32'h9000, 32'h2, 32'hC000_1000);
    drive("R3", 4'd1, 4'd1, 8'h01, 8'hFF, 32'hA000, 32'h0, 32'hC000_1000);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule